// File: doc/BRIEF.md
# Block-Scaled Integer Dot-Product Unit

This unit takes two operand blocks in a shared-exponent integer format and returns their dot product without leaving the integer domain. Each operand is one 264-bit word. It carries one unsigned power-of-two scale byte (biased by 127) and 32 signed 8-bit elements. The unit multiplies the elements pairwise, adds the 32 products in an exact 20-bit signed sum, and adds the two unbiased scale exponents. The real result is `out_sum * 2^out_exp`.

The adder tree has two register stages. A new operand pair can enter on every clock, and each result appears a fixed two cycles later. There is no stall path. A scale byte of all ones marks an operand as not-a-number. In that case the unit raises a flag and returns zero for both the sum and the exponent. Converting the result to floating point and accumulating across blocks are left to the logic downstream.

Top module: `blkdot_unit`

## Requirements
- R1: Operand layout: bits [263:256] hold the scale byte, and element i (0..31) sits in bits [8i+7:8i] as a two's-complement byte.
- R2: For a valid pair with no NaN scale, `out_sum` equals the exact sum over i of a_i * b_i, as a 20-bit two's-complement value.
- R3: The element code 0x80 is read as -127, so every element used in a product lies in [-127, +127].
- R4: For a valid pair with no NaN scale, `out_exp` equals (scale_a - 127) + (scale_b - 127), as a 10-bit two's-complement value covering -254 to +254.
- R5: If either scale byte is 0xFF, the result has `out_nan` = 1, `out_sum` = 0 and `out_exp` = 0. Otherwise `out_nan` = 0.
- R6: `out_valid` is high on exactly the cycle two rising edges after `in_valid` was sampled high. Back-to-back inputs on consecutive cycles give results on consecutive cycles.
- R7: While `out_valid` is low, `out_sum`, `out_exp` and `out_nan` keep the values of the last result.
- R8: During and right after an active-low reset, `out_valid`, `out_sum`, `out_exp` and `out_nan` are all zero.
- R9: The extreme sums +516128 (all elements +127 by +127) and -516128 (all +127 by -127) come out exactly, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 264 | First packed operand block |
| op_b | input | 264 | Second packed operand block |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 20 | Signed integer dot product |
| out_exp | output | 10 | Signed combined exponent |
| out_nan | output | 1 | Either operand scale was NaN |

## Verification
A wrong lane product or a misrouted adder-tree node changes `out_sum` on the same cycle that the affected pair's `out_valid` rises, two cycles after input. Random element bytes, including 0x80, expose such faults within a few pairs. A stage-one register that loads at the wrong time, or a valid bit that drifts out of step with its data, shows up as a result one cycle early or late. It also shows up as a changed output during idle cycles, which the hold checks catch on the first gap in the stream. Errors in the exponent path or the NaN path show in `out_exp` and `out_nan` for the pair that carried the special scale.

// File: rtl/bdot_pkg.sv
package bdot_pkg;

  localparam int ELEM_W     = 8;
  localparam int SCALE_W    = 8;
  localparam int EXP_W      = 10;
  localparam int SCALE_BIAS = 127;
  localparam logic [SCALE_W-1:0] SCALE_NAN = '1;

  // R3: the asymmetric code is folded onto the symmetric range
  function automatic logic signed [ELEM_W-1:0] elem_value(input logic [ELEM_W-1:0] code);
    logic signed [ELEM_W-1:0] v;
    v = $signed(code);
    if (code == {1'b1, {(ELEM_W-1){1'b0}}}) v = -$signed(ELEM_W'(SCALE_BIAS));
    return v;
  endfunction

  function automatic logic scale_is_nan(input logic [SCALE_W-1:0] s);
    return s == SCALE_NAN;
  endfunction

  // R4: sum of the two unbiased exponents
  function automatic logic signed [EXP_W-1:0] exp_join(input logic [SCALE_W-1:0] sa,
                                                       input logic [SCALE_W-1:0] sb);
    logic signed [EXP_W-1:0] ea;
    logic signed [EXP_W-1:0] eb;
    ea = $signed(EXP_W'(sa)) - EXP_W'(SCALE_BIAS);
    eb = $signed(EXP_W'(sb)) - EXP_W'(SCALE_BIAS);
    return ea + eb;
  endfunction

endpackage

// File: rtl/bdot_lane.sv
module bdot_lane import bdot_pkg::*; #(
  parameter int SUM_W = 20
) (
  input  logic [ELEM_W-1:0] a_code,
  input  logic [ELEM_W-1:0] b_code,
  output logic [SUM_W-1:0]  prod
);

  logic signed [ELEM_W-1:0]   a_val;
  logic signed [ELEM_W-1:0]   b_val;
  logic signed [2*ELEM_W-1:0] p;

  always_comb begin
    a_val = elem_value(a_code);
    b_val = elem_value(b_code);
    p     = a_val * b_val;
    prod  = SUM_W'(p);
  end

endmodule

// File: rtl/bdot_adder_tree.sv
module bdot_adder_tree #(
  parameter int IN_N   = 32,
  parameter int LEVELS = 2,
  parameter int W      = 20,
  localparam int OUT_N = IN_N >> LEVELS
) (
  input  logic [IN_N-1:0][W-1:0]  in_vec,
  output logic [OUT_N-1:0][W-1:0] out_vec
);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int N = IN_N >> l;
    logic [N-1:0][W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = in_vec;
    end else begin : g_node
      for (genvar k = 0; k < N; k++) begin : g_add
        assign v[k] = g_lvl[l-1].v[2*k] + g_lvl[l-1].v[2*k+1];
      end
    end
  end

  assign out_vec = g_lvl[LEVELS].v;

endmodule

// File: rtl/blkdot_unit.sv
module blkdot_unit import bdot_pkg::*; #(
  parameter int LANES = 32,
  parameter int SPLIT = 2,
  localparam int OPW   = SCALE_W + LANES * ELEM_W,
  localparam int SUM_W = 2 * ELEM_W - 1 + $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [OPW-1:0]          op_a,
  input  logic [OPW-1:0]          op_b,
  output logic                    out_valid,
  output logic signed [SUM_W-1:0] out_sum,
  output logic signed [EXP_W-1:0] out_exp,
  output logic                    out_nan
);

  localparam int LVLS  = $clog2(LANES);
  localparam int MID_N = LANES >> SPLIT;

  // R1: scale in the top byte, lanes from the bottom up
  logic [SCALE_W-1:0] scale_a;
  logic [SCALE_W-1:0] scale_b;
  assign scale_a = op_a[OPW-1 -: SCALE_W];
  assign scale_b = op_b[OPW-1 -: SCALE_W];

  logic [LANES-1:0][SUM_W-1:0] prod;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bdot_lane #(.SUM_W(SUM_W)) u_lane (
      .a_code (op_a[i*ELEM_W +: ELEM_W]),
      .b_code (op_b[i*ELEM_W +: ELEM_W]),
      .prod   (prod[i])
    );
  end

  logic [MID_N-1:0][SUM_W-1:0] mid;
  bdot_adder_tree #(.IN_N(LANES), .LEVELS(SPLIT), .W(SUM_W)) u_front (
    .in_vec  (prod),
    .out_vec (mid)
  );

  logic                    in_nan;
  logic signed [EXP_W-1:0] in_exp;
  assign in_nan = scale_is_nan(scale_a) | scale_is_nan(scale_b);
  assign in_exp = exp_join(scale_a, scale_b);

  // stage 1: partial sums after the front levels
  logic                    s1_valid;
  logic                    s1_nan;
  logic signed [EXP_W-1:0] s1_exp;
  logic [MID_N-1:0][SUM_W-1:0] s1_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_nan   <= 1'b0;
      s1_exp   <= '0;
      s1_part  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_nan  <= in_nan;
        s1_exp  <= in_exp;
        s1_part <= mid;
      end
    end
  end

  logic [0:0][SUM_W-1:0] fin;
  bdot_adder_tree #(.IN_N(MID_N), .LEVELS(LVLS - SPLIT), .W(SUM_W)) u_back (
    .in_vec  (s1_part),
    .out_vec (fin)
  );

  // stage 2: final result, NaN forces zeros
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_exp   <= '0;
      out_nan   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_sum <= s1_nan ? '0 : $signed(fin[0]);
        out_exp <= s1_nan ? '0 : s1_exp;
        out_nan <= s1_nan;
      end
    end
  end

endmodule

// File: rtl/bdot_chk.sv
module bdot_chk import bdot_pkg::*; #(
  parameter int LANES = 32,
  parameter int OPW   = 264,
  parameter int SUM_W = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [OPW-1:0]          op_a,
  input logic [OPW-1:0]          op_b,
  input logic                    s1_valid,
  input logic                    s1_nan,
  input logic                    out_valid,
  input logic signed [SUM_W-1:0] out_sum,
  input logic signed [EXP_W-1:0] out_exp,
  input logic                    out_nan
);

  localparam int LIM = LANES * SCALE_BIAS * SCALE_BIAS;

  logic nan_seen;
  assign nan_seen = (op_a[OPW-1 -: SCALE_W] == SCALE_NAN) || (op_b[OPW-1 -: SCALE_W] == SCALE_NAN);

  // R6
  stage_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));

  // R6
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));

  // R5
  nan_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> s1_nan == $past(nan_seen));

  // R5
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nan) |-> (out_sum == '0 && out_exp == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sum) && $stable(out_exp) && $stable(out_nan)));

  // R9
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sum) <= LIM && int'(out_sum) >= -LIM));

  // R4
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nan) |-> (int'(out_exp) <= 2 * SCALE_BIAS && int'(out_exp) >= -2 * SCALE_BIAS));

endmodule

bind blkdot_unit bdot_chk #(.LANES(LANES), .OPW(OPW), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .s1_valid  (s1_valid),
  .s1_nan    (s1_nan),
  .out_valid (out_valid),
  .out_sum   (out_sum),
  .out_exp   (out_exp),
  .out_nan   (out_nan)
);

// File: tb/tb_blkdot_unit.sv
module tb_blkdot_unit;

  localparam int VW = 264;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] op_a = '0;
  logic [VW-1:0] op_b = '0;
  logic          out_valid;
  logic signed [19:0] out_sum;
  logic signed [9:0]  out_exp;
  logic          out_nan;

  always #10 clk = ~clk;

  blkdot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_sum(out_sum), .out_exp(out_exp), .out_nan(out_nan)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int dec(input logic [7:0] c);
    int v;
    v = int'($signed(c));
    if (v == -128) v = -127;   // R3
    return v;
  endfunction

  task automatic model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       output int s, output int e, output bit n);
    int sa, sb;
    sa = int'(a[263:256]);
    sb = int'(b[263:256]);
    n  = (sa == 255) || (sb == 255);
    s = 0;
    for (int i = 0; i < 32; i++) s += dec(a[8*i +: 8]) * dec(b[8*i +: 8]);
    e = (sa - 127) + (sb - 127);
    if (n) begin s = 0; e = 0; end
  endtask

  // two-deep record of what was driven
  bit    p1_v, p2_v;
  int    p1_s, p2_s, p1_e, p2_e;
  bit    p1_n, p2_n;
  string p1_t, p2_t;
  int    last_s = 0, last_e = 0, last_n = 0;

  task automatic step(input bit v, input logic [VW-1:0] a, input logic [VW-1:0] b, input string tag);
    int s, e;
    bit n;
    @(negedge clk);
    if (p2_v) begin
      chk("R6 valid", int'(out_valid), 1);
      chk({tag_of2(), " sum"}, int'(out_sum), p2_s);
      chk("R4 exp", int'(out_exp), p2_e);
      chk("R5 nan", int'(out_nan), int'(p2_n));
      last_s = p2_s; last_e = p2_e; last_n = int'(p2_n);
    end else begin
      chk("R6 idle", int'(out_valid), 0);
      chk("R7 hold sum", int'(out_sum), last_s);
      chk("R7 hold exp", int'(out_exp), last_e);
      chk("R7 hold nan", int'(out_nan), last_n);
    end
    model(a, b, s, e, n);
    in_valid = v;
    op_a = a;
    op_b = b;
    p2_v = p1_v; p2_s = p1_s; p2_e = p1_e; p2_n = p1_n; p2_t = p1_t;
    p1_v = v;    p1_s = s;    p1_e = e;    p1_n = n;    p1_t = tag;
  endtask

  function automatic string tag_of2();
    return p2_t;
  endfunction

  function automatic logic [VW-1:0] fill(input logic [7:0] sc, input logic [7:0] el);
    logic [VW-1:0] w;
    w[263:256] = sc;
    for (int i = 0; i < 32; i++) w[8*i +: 8] = el;
    return w;
  endfunction

  function automatic logic [VW-1:0] rnd_op();
    logic [VW-1:0] w;
    for (int i = 0; i < 32; i++) w[8*i +: 8] = 8'($urandom_range(0, 255));
    w[263:256] = ($urandom_range(0, 15) == 0) ? 8'hFF : 8'($urandom_range(0, 254));
    return w;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    logic [VW-1:0] a, b;
    void'($urandom(32'd4242));
    p1_v = 0; p2_v = 0; p1_t = "R2"; p2_t = "R2";
    repeat (3) @(posedge clk);
    // R8: outputs at reset
    @(negedge clk);
    chk("R8 valid", int'(out_valid), 0);
    chk("R8 sum", int'(out_sum), 0);
    chk("R8 exp", int'(out_exp), 0);
    chk("R8 nan", int'(out_nan), 0);
    rst_n = 1'b1;
    step(0, '0, '0, "R2");

    // R9: extremes, R3: 0x80 folding
    step(1, fill(8'd127, 8'd127), fill(8'd127, 8'd127), "R9");
    step(1, fill(8'd127, 8'd127), fill(8'd127, 8'h81), "R9");
    step(1, fill(8'd127, 8'h80), fill(8'd127, 8'h80), "R3");
    step(1, fill(8'd127, 8'h80), fill(8'd127, 8'd1), "R3");
    // R1: only the first and last lanes carry data, distinct scales
    a = '0; b = '0;
    a[263:256] = 8'd130; b[263:256] = 8'd120;
    a[7:0] = 8'd3; b[7:0] = 8'd5; a[255:248] = 8'hFE; b[255:248] = 8'd100;
    step(1, a, b, "R1");
    // R4: exponent extremes
    step(1, fill(8'd0, 8'd1), fill(8'd0, 8'd1), "R4");
    step(1, fill(8'd254, 8'd2), fill(8'd254, 8'hFF), "R4");
    step(0, '0, '0, "R2");
    step(0, '0, '0, "R2");
    // R5: NaN on either side
    step(1, fill(8'hFF, 8'd9), fill(8'd127, 8'd9), "R5");
    step(1, fill(8'd127, 8'd9), fill(8'hFF, 8'd9), "R5");
    step(0, '0, '0, "R2");
    step(1, fill(8'd127, 8'd0), fill(8'd127, 8'd77), "R2");
    // random traffic with gaps
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 3) != 0, rnd_op(), rnd_op(), "R2");
    end
    step(0, '0, '0, "R2");
    step(0, '0, '0, "R2");
    step(0, '0, '0, "R2");
    finished = 1'b1;
    summary();
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule